// File: doc/BRIEF.md
# Single-Channel Device-to-Memory DMA Engine

This block copies a block of words from a device's valid/ready data port into memory on behalf of one channel. Software programs a base address, a word count and a transfer mode, then pulses start. The engine raises a request to the bus arbiter and writes only while the arbiter grants the bus and the device offers a word. The memory address advances by one for every accepted word.

Two modes are offered. In burst mode the engine keeps its request up for the whole block, so the block can go through under one grant, and it inserts wait cycles whenever the device has nothing to give. In word-by-word mode it drops its request for one cycle after every word, so other masters can win the bus between words. When the last word is written, the engine releases the bus and raises a sticky interrupt that software clears with a pulse.

Top module: `dma_burst_engine`

## Requirements
- R1: `mem_we` and `dev_ready` are high only in cycles where `bus_req` and `bus_gnt` are both high. While `bus_req` and `bus_gnt` are high, `dev_ready` is high, and a word is written (`mem_we` high) exactly when `dev_valid` is also high.
- R2: In burst mode (`cfg_burst`=1), `bus_req` stays high in every cycle from the cycle after start until the cycle that writes the final word, whether or not grant is held.
- R3: In word-by-word mode (`cfg_burst`=0), `bus_req` is low in the cycle after each word that is not the final one, and high again in the cycle after that.
- R4: The k-th word of a block (k counted from 0) is written at address `cfg_base`+k, modulo 2^ADDR_W.
- R5: `mem_wdata` equals `dev_data` in every write cycle. Exactly `cfg_count` words are written per block, and no more after that.
- R6: In burst mode, a granted cycle with `dev_valid` low writes nothing, and `bus_req` stays high.
- R7: In the cycle after the final word is written, `irq` is high and `bus_req` is low.
- R8: `irq` stays high until a cycle with `irq_clr` high, and it is low in the following cycle. If completion and `irq_clr` fall in the same cycle, completion wins.
- R9: A start pulse while a block is in progress is ignored. The base, count and mode of the running block are kept.
- R10: A start with `cfg_count`=0 raises `irq` in the next cycle, and `bus_req` is never asserted.
- R11: A start with `cfg_count`=1 writes exactly one word, at `cfg_base`.
- R12: During reset and right after it, `bus_req`, `mem_we`, `dev_ready` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a block with the current configuration |
| cfg_base | input | ADDR_W | First memory address of the block |
| cfg_count | input | CNT_W | Number of words in the block |
| cfg_burst | input | 1 | 1 = hold the bus for the whole block, 0 = one word per request |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| dev_valid | input | 1 | Device offers a word |
| dev_ready | output | 1 | Engine can take a word this cycle |
| dev_data | input | DATA_W | Word offered by the device |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| irq | output | 1 | Completion interrupt, sticky |
| irq_clr | input | 1 | Clear pulse for the interrupt |

## Verification
The bench builds the engine with ADDR_W=4, DATA_W=8 and CNT_W=3. With these values every legal word count from 0 to 7 can be swept in both modes. Starting a seven-word block at base 11 makes the address wrap past 15. The arbiter and the device are modelled with arithmetic patterns that differ per case, so grant gaps and device stalls land on first, middle and last words, and the expected address, data and request shape are computed directly from the case's base, count and mode.

// File: rtl/dma_pkg.sv
// Shared types for the DMA engine.
// Assumes: nothing beyond a standard elaborator.
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for start
        ST_BUS  = 2'd1,   // requesting / holding the bus
        ST_GAP  = 2'd2    // one-cycle release between words in word-by-word mode
    } dma_state_e;
endpackage

// File: rtl/dma_xfer_counter.sv
// Address and remaining-word counter for one block.
// Assumes: load and step are never high in the same cycle (the controller
// only loads when idle and only steps when busy).
module dma_xfer_counter #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  words_left,
    output logic              last_word
);
    localparam logic [CNT_W-1:0] ONE_WORD = CNT_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;

    // Load the block on start, then advance by one word per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load) begin
            addr_q <= base;
            left_q <= count;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    // Expose counter state and the final-word flag.
    always_comb begin
        addr       = addr_q;
        words_left = left_q;
        last_word  = (left_q == ONE_WORD);
    end
endmodule

// File: rtl/dma_ctrl_fsm.sv
// Bus request / transfer sequencer. It requests the bus, moves one word per
// granted and valid cycle, and in word-by-word mode releases the bus for one
// cycle between words.
// Assumes: the arbiter holds bus_gnt low whenever bus_req is low.
module dma_ctrl_fsm
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic count_zero,
    input  logic cfg_burst,
    input  logic bus_gnt,
    input  logic dev_valid,
    input  logic last_word,
    output logic load,
    output logic bus_req,
    output logic dev_ready,
    output logic step,
    output logic done,
    output logic burst_mode
);
    dma_state_e state_q, state_d;
    logic       burst_q;
    logic       busy;

    // Decode handshakes and completion from the current state.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        load      = start && !busy;
        bus_req   = (state_q == ST_BUS);
        dev_ready = bus_req && bus_gnt;
        step      = dev_ready && dev_valid;
        done      = (load && count_zero) || (step && last_word);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load && !count_zero) state_d = ST_BUS;
            ST_BUS: begin
                if (step) begin
                    if (last_word)     state_d = ST_IDLE;
                    else if (!burst_q) state_d = ST_GAP;
                end
            end
            ST_GAP:  state_d = ST_BUS;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and latched mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            burst_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) burst_q <= cfg_burst;
        end
    end

    // Expose the latched mode for the checker.
    always_comb burst_mode = burst_q;
endmodule

// File: rtl/dma_irq_latch.sv
// Sticky completion interrupt. Completion takes priority over a clear that
// arrives in the same cycle.
// Assumes: done is a single-cycle pulse.
module dma_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic irq_clr,
    output logic irq
);
    logic irq_q;

    // Set on completion, hold until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (done)    irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    // Drive the output from the flop.
    always_comb irq = irq_q;
endmodule

// File: rtl/dma_burst_engine.sv
// Top level of the single-channel device-to-memory DMA engine.
// Assumes: the memory accepts a write in any cycle mem_we is high, and the
// configuration inputs are stable in the cycle start is high.
module dma_burst_engine #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_burst,
    output logic              bus_req,
    input  logic              bus_gnt,
    input  logic              dev_valid,
    output logic              dev_ready,
    input  logic [DATA_W-1:0] dev_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              irq,
    input  logic              irq_clr
);
    logic             load;
    logic             step;
    logic             done;
    logic             last_word;
    logic             count_zero;
    logic             burst_mode;
    logic [CNT_W-1:0] words_left;

    // Detect an empty block at start.
    always_comb count_zero = (cfg_count == '0);

    dma_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .count_zero (count_zero),
        .cfg_burst  (cfg_burst),
        .bus_gnt    (bus_gnt),
        .dev_valid  (dev_valid),
        .last_word  (last_word),
        .load       (load),
        .bus_req    (bus_req),
        .dev_ready  (dev_ready),
        .step       (step),
        .done       (done),
        .burst_mode (burst_mode)
    );

    dma_xfer_counter #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .base       (cfg_base),
        .count      (cfg_count),
        .addr       (mem_addr),
        .words_left (words_left),
        .last_word  (last_word)
    );

    dma_irq_latch u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done),
        .irq_clr (irq_clr),
        .irq     (irq)
    );

    // Memory write port: data passes straight from the device.
    always_comb begin
        mem_we    = step;
        mem_wdata = dev_data;
    end
endmodule

// File: rtl/dma_burst_engine_chk.sv
// Protocol checker for dma_burst_engine, attached with bind.
// Assumes: connected to the engine's ports and its counter / mode state.
module dma_burst_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_we,
    input logic              dev_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq,
    input logic              irq_clr,
    input logic              burst_mode,
    input logic [CNT_W-1:0]  words_left
);
    // R1
    write_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (bus_req && bus_gnt));

    // R1
    ready_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ready |-> (bus_req && bus_gnt));

    // R3
    single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !burst_mode && words_left != CNT_W'(1)) |=> !bus_req);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_we) && $past(words_left) != CNT_W'(1))
            |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    // R6
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && burst_mode && !(mem_we && words_left == CNT_W'(1))) |=> bus_req);

    // R7
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && words_left == CNT_W'(1)) |=> (irq && !bus_req));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R10
    no_empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> words_left != '0);
endmodule

bind dma_burst_engine dma_burst_engine_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .mem_we     (mem_we),
    .dev_ready  (dev_ready),
    .mem_addr   (mem_addr),
    .irq        (irq),
    .irq_clr    (irq_clr),
    .burst_mode (burst_mode),
    .words_left (words_left)
);

// File: tb/dma_burst_engine_test.sv
// Sweep bench: every count in both modes, two bases, arithmetic arbiter and
// device patterns, expected values computed from the requirements.
module dma_burst_engine_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          cfg_burst = 1'b0;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          dev_valid = 1'b0;
    logic          dev_ready;
    logic [DW-1:0] dev_data = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          irq;
    logic          irq_clr = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dma_burst_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
        .cfg_count(cfg_count), .cfg_burst(cfg_burst), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .dev_valid(dev_valid), .dev_ready(dev_ready),
        .dev_data(dev_data), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .irq(irq), .irq_clr(irq_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word_val(input int k, input int seed);
        return DW'(k * 29 + seed * 7 + 5);
    endfunction

    // One block: start it, model arbiter and device, check every cycle.
    // poke: withhold grant briefly and issue a conflicting start (R9).
    // clr_last: raise irq_clr in the final word's cycle (R8 priority).
    task automatic run_case(input int base, input int cnt, input bit burst,
                            input int seed, input bit poke, input bit clr_last);
        int  k = 0;
        bit  prev_wr = 1'b0;
        bit  g;
        string tag;
        @(negedge clk);
        cfg_base = AW'(base); cfg_count = CW'(cnt); cfg_burst = burst; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 300 && k < cnt; cyc++) begin
            if (burst)        chk(bus_req == 1'b1, "R2 request held in burst", bus_req, 1);
            else if (prev_wr) chk(bus_req == 1'b0, "R3 release after word", bus_req, 0);
            else              chk(bus_req == 1'b1, "R3 request outside gap", bus_req, 1);
            g = ((cyc * seed + 1) % 4) != 0;
            if (poke && cyc < 3) g = 1'b0;
            start = 1'b0;
            if (poke && cyc == 1) begin
                start = 1'b1; cfg_base = AW'(base + 7); cfg_count = CW'(7); cfg_burst = ~burst;
            end
            bus_gnt   = bus_req && g;
            dev_valid = ((cyc * 3 + seed) % 5) != 0;
            dev_data  = word_val(k, seed);
            irq_clr   = clr_last && (k == cnt - 1);
            #1;
            chk(mem_we == (bus_req && bus_gnt && dev_valid), "R1 write strobe", mem_we,
                int'(bus_req && bus_gnt && dev_valid));
            chk(dev_ready == (bus_req && bus_gnt), "R1 ready gating", dev_ready,
                int'(bus_req && bus_gnt));
            if (bus_req && bus_gnt && !dev_valid && burst)
                chk(mem_we == 1'b0, "R6 stall writes nothing", mem_we, 0);
            if (mem_we) begin
                chk(mem_addr == AW'(base + k), poke ? "R9 address kept" : "R4 address",
                    mem_addr, (base + k) % (1 << AW));
                chk(mem_wdata == word_val(k, seed), "R5 data", mem_wdata, word_val(k, seed));
                k++;
            end
            prev_wr = mem_we;
            @(negedge clk);
        end
        start = 1'b0; irq_clr = 1'b0;
        chk(k == cnt, poke ? "R9 word count kept" : "R5 word count", k, cnt);
        tag = (cnt == 0) ? "R10 empty block" : (cnt == 1) ? "R11 single word" : "R7 completion";
        chk(irq == 1'b1, tag, irq, 1);
        chk(bus_req == 1'b0, tag, bus_req, 0);
        // Idle with a willing bus and device: nothing more may be written.
        for (int i = 0; i < 3; i++) begin
            bus_gnt = 1'b1; dev_valid = 1'b1;
            #1;
            chk(mem_we == 1'b0, cnt == 0 ? "R10 no write" : "R5 no extra write", mem_we, 0);
            chk(bus_req == 1'b0, cnt == 0 ? "R10 no request" : "R7 bus released", bus_req, 0);
            @(negedge clk);
            chk(irq == 1'b1, "R8 irq held", irq, 1);
        end
        bus_gnt = 1'b0; dev_valid = 1'b0;
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq == 1'b0, "R8 irq cleared", irq, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(bus_req == 1'b0, "R12 reset bus_req", bus_req, 0);
        chk(mem_we == 1'b0, "R12 reset mem_we", mem_we, 0);
        chk(dev_ready == 1'b0, "R12 reset dev_ready", dev_ready, 0);
        chk(irq == 1'b0, "R12 reset irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req == 1'b0 && irq == 1'b0, "R12 after reset", int'(bus_req || irq), 0);

        for (int m = 0; m < 2; m++)
            for (int b = 0; b < 2; b++)
                for (int c = 0; c < 8; c++)
                    run_case(b ? 11 : 0, c, bit'(m), c + b * 5 + m * 3 + 1, 1'b0, 1'b0);

        run_case(2, 5, 1'b1, 6, 1'b1, 1'b0);   // R9 start ignored while busy
        run_case(9, 4, 1'b0, 3, 1'b1, 1'b0);   // R9 in word-by-word mode
        // R8: irq already set, clear raised in the final word's cycle
        @(negedge clk);
        cfg_count = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(irq == 1'b1, "R10 irq set before priority test", irq, 1);
        run_case(5, 3, 1'b1, 2, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule